// File: doc/BRIEF.md
# DMA Address Translation Walker

This block stands between DMA-capable devices and system memory. Each request names a requester (bus, device and function packed into 16 bits), an I/O virtual address and a direction. The walker finds the device's translation domain in two steps. A root table indexed by bus gives a context table. That context table, indexed by device and function, gives the top of a four-level page table. The walker then reads one 64-bit entry per level through a single memory port. It returns either a physical address or a fault carrying a reason code.

On a permitted access the walker marks the final entry as accessed, and on a permitted write also as dirty. It writes the entry back only when it changes, and the write completes before the response is raised. A faulted request never reaches memory: the device receives an Unsupported Request completion, and software is told about the fault. The walker handles one request at a time and has one memory access in flight at most.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0.
- R2: The root entry is read at `root_frame`×4096 + bus×8, where bus is `req_rid[15:8]`. The context entry is read at (root entry bits 51:12)×4096 + `req_rid[7:0]`×8. In both tables bit 0 marks the entry valid and bits 51:12 give the next frame. A root or context entry with bit 0 clear gives a fault with reason 1.
- R3: The page table has four levels, indexed in turn by IOVA bits 47:39, 38:30, 29:21 and 20:12. Each entry sits at its table frame×4096 + index×8. A successful result is `resp_pa` = final entry bits 51:12 concatenated with IOVA bits 11:0, with `resp_fault` = 0 and `resp_reason` = 0.
- R4: A page-table entry at any level whose bits 1:0 are both 0 is not present and gives a fault with reason 1. This covers an empty domain.
- R5: Bit 0 of a page-table entry grants read and bit 1 grants write; both are checked at every level. A read through an entry with bit 0 clear gives reason 2. A write through an entry with bit 1 clear gives reason 3.
- R6: On success the final entry gets bit 5 (accessed) set, and on a write also bit 6 (dirty). All other bits of the entry are kept.
- R7: The walker writes the entry back only when its value changes, and that write is acknowledged before `resp_valid` rises.
- R8: A faulted response has `resp_pa` = 0 and writes nothing to memory. Every response echoes the IOVA, the requester ID and the direction of its request.
- R9: `req_ready` falls in the cycle after a request is accepted and stays low until the response. `resp_valid` lasts one cycle. At most one memory access is outstanding.
- R10: Bits 63:52 and the snoop hint in bit 11 of an entry have no effect on the translated address or on the checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | PA_W-12 | Frame number of the root table |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_rid | input | 16 | Requester ID: bus[15:8], device[7:3], function[2:0] |
| req_iova | input | IOVA_W | I/O virtual address |
| req_write | input | 1 | 1 = write request, 0 = read |
| mem_req_valid | output | 1 | One-cycle memory access request |
| mem_req_write | output | 1 | Access is an entry write-back |
| mem_req_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_req_wdata | output | 64 | Updated entry value |
| mem_rsp_valid | input | 1 | Read data valid or write acknowledged |
| mem_rsp_rdata | input | 64 | Entry read data |
| resp_valid | output | 1 | Translation result, one cycle |
| resp_fault | output | 1 | Request blocked |
| resp_reason | output | 2 | 0 ok, 1 not present, 2 read denied, 3 write denied |
| resp_pa | output | PA_W | Translated physical address |
| resp_iova | output | IOVA_W | Echo of the request address |
| resp_rid | output | 16 | Echo of the requester ID |
| resp_write | output | 1 | Echo of the direction |

## Verification
The assertions assume the memory answers only while an access is outstanding, with exactly one `mem_rsp_valid` pulse per `mem_req_valid`. The bench memory model meets this by construction: it returns a pulse one cycle after each request and never otherwise. The assertions also assume that requests are offered only against `req_ready`. The driver keeps to this by waiting for ready before it raises `req_valid` for one cycle.

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker #(
  parameter int PA_W   = 52,
  parameter int IOVA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-13:0]  root_frame,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_rid,
  input  logic [IOVA_W-1:0] req_iova,
  input  logic              req_write,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_rdata,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [1:0]        resp_reason,
  output logic [PA_W-1:0]   resp_pa,
  output logic [IOVA_W-1:0] resp_iova,
  output logic [15:0]       resp_rid,
  output logic              resp_write
);
  localparam int IDX_W = 9;
  localparam int FR_W  = PA_W - 12;

  typedef enum logic [2:0] {S_IDLE, S_ROOT, S_CTX, S_WALK, S_WB, S_RESP} state_t;

  state_t            state;
  logic              waiting;
  logic [1:0]        lvl;
  logic [FR_W-1:0]   frame;
  logic [15:0]       q_rid;
  logic [IOVA_W-1:0] q_iova;
  logic              q_wr;
  logic [63:0]       pte;
  logic [PA_W-1:0]   wb_addr;
  logic [IDX_W-1:0]  lvl_idx, cur_idx;
  logic [PA_W-1:0]   ent_addr;
  logic [63:0]       new_pte;
  logic [1:0]        code;

  always_comb begin
    case (lvl)
      2'd3:    lvl_idx = q_iova[12+3*IDX_W +: IDX_W];
      2'd2:    lvl_idx = q_iova[12+2*IDX_W +: IDX_W];
      2'd1:    lvl_idx = q_iova[12+IDX_W +: IDX_W];
      default: lvl_idx = q_iova[12 +: IDX_W];
    endcase
  end

  assign cur_idx  = (state == S_ROOT) ? {{(IDX_W-8){1'b0}}, q_rid[15:8]} :
                    (state == S_CTX)  ? {{(IDX_W-8){1'b0}}, q_rid[7:0]}  : lvl_idx;
  assign ent_addr = {frame, 12'b0} + {{(PA_W-IDX_W-3){1'b0}}, cur_idx, 3'b000};
  assign new_pte  = mem_rsp_rdata | 64'h20 | (q_wr ? 64'h40 : 64'h0);

  always_comb begin
    code = 2'd0;
    if (state == S_ROOT || state == S_CTX)
      code = mem_rsp_rdata[0] ? 2'd0 : 2'd1;
    else if (state == S_WALK) begin
      if (mem_rsp_rdata[1:0] == 2'b00)     code = 2'd1;
      else if (!q_wr && !mem_rsp_rdata[0]) code = 2'd2;
      else if (q_wr && !mem_rsp_rdata[1])  code = 2'd3;
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign resp_valid    = (state == S_RESP);
  assign mem_req_valid = !waiting && (state == S_ROOT || state == S_CTX ||
                                      state == S_WALK || state == S_WB);
  assign mem_req_write = (state == S_WB);
  assign mem_req_addr  = (state == S_WB) ? wb_addr : ent_addr;
  assign mem_req_wdata = pte;
  assign resp_iova     = q_iova;
  assign resp_rid      = q_rid;
  assign resp_write    = q_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; waiting <= 1'b0; lvl <= 2'd0; frame <= '0;
      q_rid <= '0; q_iova <= '0; q_wr <= 1'b0; pte <= '0; wb_addr <= '0;
      resp_fault <= 1'b0; resp_reason <= 2'd0; resp_pa <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          q_rid <= req_rid; q_iova <= req_iova; q_wr <= req_write;
          frame <= root_frame; waiting <= 1'b0; state <= S_ROOT;
        end
        S_ROOT, S_CTX, S_WALK: begin
          if (!waiting) waiting <= 1'b1;
          else if (mem_rsp_valid) begin
            waiting <= 1'b0;
            if (code != 2'd0) begin
              resp_fault <= 1'b1; resp_reason <= code; resp_pa <= '0; state <= S_RESP;
            end else if (state == S_ROOT) begin
              frame <= mem_rsp_rdata[PA_W-1:12]; state <= S_CTX;
            end else if (state == S_CTX) begin
              frame <= mem_rsp_rdata[PA_W-1:12]; lvl <= 2'd3; state <= S_WALK;
            end else if (lvl != 2'd0) begin
              frame <= mem_rsp_rdata[PA_W-1:12]; lvl <= lvl - 2'd1;
            end else begin
              resp_fault <= 1'b0; resp_reason <= 2'd0;
              resp_pa <= {mem_rsp_rdata[PA_W-1:12], q_iova[11:0]};
              pte <= new_pte; wb_addr <= ent_addr;
              state <= (new_pte != mem_rsp_rdata) ? S_WB : S_RESP;
            end
          end
        end
        S_WB: begin
          if (!waiting) waiting <= 1'b1;
          else if (mem_rsp_valid) begin waiting <= 1'b0; state <= S_RESP; end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xlate_walker_chk.sv
module dma_xlate_walker_chk #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_write,
  input logic [63:0]     mem_req_wdata,
  input logic            mem_rsp_valid,
  input logic            resp_valid,
  input logic            resp_fault,
  input logic [PA_W-1:0] resp_pa
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_req_valid) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outstanding);
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_wb_done_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !outstanding);
  assert_wb_sets_accessed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]);
  assert_fault_no_pa_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_pa == '0));
endmodule

bind dma_xlate_walker dma_xlate_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/dma_xlate_walker_test.sv
module dma_xlate_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] root_frame = 40'h100;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [15:0] req_rid = '0;
  logic [47:0] req_iova = '0;
  logic        mem_req_valid, mem_req_write, mem_rsp_valid = 1'b0;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata, mem_rsp_rdata = '0;
  logic        resp_valid, resp_fault, resp_write;
  logic [1:0]  resp_reason;
  logic [51:0] resp_pa;
  logic [47:0] resp_iova;
  logic [15:0] resp_rid;

  always #10 clk = ~clk;

  dma_xlate_walker uut (.*);

  typedef struct {
    logic [51:0] pa; logic fault; logic [1:0] reason;
    logic [47:0] iova; logic [15:0] rid; logic wr;
    int nwr; logic [51:0] paddr; logic [63:0] pval; string tag;
  } exp_t;

  exp_t expq[$];
  logic [63:0] mem [logic [51:0]];
  int n_chk = 0, n_fail = 0, wr_count = 0, last_wr = 0;

  function automatic logic [63:0] mrd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, expv);
    end
  endtask

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid;
    if (mem_req_valid) begin
      if (mem_req_write) begin mem[mem_req_addr] = mem_req_wdata; wr_count++; end
      else mem_rsp_rdata <= mrd(mem_req_addr);
    end
  end

  function automatic logic [47:0] mk(input int a, input int b, input int c, input int d, input int off);
    return (48'(a) << 39) | (48'(b) << 30) | (48'(c) << 21) | (48'(d) << 12) | 48'(off);
  endfunction

  function automatic void ref_walk(input logic [15:0] rid, input logic [47:0] iova,
                                   input logic wr, output exp_t e);
    logic [63:0] ent; logic [51:0] a; logic [39:0] fr;
    e.iova = iova; e.rid = rid; e.wr = wr; e.nwr = 0; e.pa = '0;
    e.fault = 1'b1; e.reason = 2'd1;
    fr = root_frame;
    a = {fr, 12'b0} + 52'(rid[15:8]) * 8; ent = mrd(a);
    e.paddr = a; e.pval = ent;
    if (!ent[0]) return;
    fr = ent[51:12];
    a = {fr, 12'b0} + 52'(rid[7:0]) * 8; ent = mrd(a);
    e.paddr = a; e.pval = ent;
    if (!ent[0]) return;
    fr = ent[51:12];
    for (int l = 3; l >= 0; l--) begin
      a = {fr, 12'b0} + 52'(iova[12 + 9*l +: 9]) * 8; ent = mrd(a);
      e.paddr = a; e.pval = ent;
      if (ent[1:0] == 2'b00) begin e.reason = 2'd1; return; end
      if (!wr && !ent[0]) begin e.reason = 2'd2; return; end
      if (wr && !ent[1]) begin e.reason = 2'd3; return; end
      fr = ent[51:12];
    end
    e.fault = 1'b0; e.reason = 2'd0;
    e.pa = {fr, iova[11:0]};
    e.pval = ent | 64'h20 | (wr ? 64'h40 : 64'h0);
    e.nwr = (e.pval != ent) ? 1 : 0;
  endfunction

  task automatic issue(input logic [15:0] rid, input logic [47:0] iova, input logic wr, input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ref_walk(rid, iova, wr, e);
    e.tag = tag;
    expq.push_back(e);
    req_rid = rid; req_iova = iova; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", 64'(req_ready), 64'h0);
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R9 unexpected response", 64'h1, 64'h0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk({resp_fault, resp_reason, resp_pa} == {e.fault, e.reason, e.pa}, e.tag,
            64'({resp_fault, resp_reason, resp_pa}), 64'({e.fault, e.reason, e.pa}));
        chk({resp_iova, resp_rid, resp_write} == {e.iova, e.rid, e.wr}, "R8 echo",
            64'({resp_iova, resp_write}), 64'({e.iova, e.wr}));
        chk(wr_count - last_wr == e.nwr, "R7 write-back count",
            64'(wr_count - last_wr), 64'(e.nwr));
        last_wr = wr_count;
        chk(mrd(e.paddr) == e.pval, e.fault ? "R8 entry untouched" : "R6 entry update",
            mrd(e.paddr), e.pval);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    mem[52'h100018] = 64'h200001;
    mem[52'h200150] = 64'h300001;
    mem[52'h200158] = 64'h400001;
    mem[52'h300008] = 64'h301003;
    mem[52'h301010] = 64'h302003;
    mem[52'h302018] = 64'h303003;
    mem[52'h302028] = 64'h304001;
    mem[52'h303020] = 64'hABCDE003;
    mem[52'h303028] = 64'hABCDF001;
    mem[52'h303030] = 64'hABCE0002;
    mem[52'h303040] = 64'hFFF0_0000_1234_5823;
    mem[52'h304000] = 64'h55555003;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid, "R1 reset state",
        64'({req_ready, resp_valid, mem_req_valid}), 64'b100);
    rst_n = 1'b1;

    issue(16'h032A, mk(1,2,3,4,12'hABC), 1'b0, "R3 read translation");
    issue(16'h032A, mk(1,2,3,4,12'h010), 1'b0, "R7 read, accessed already set");
    issue(16'h032A, mk(1,2,3,4,12'hFFF), 1'b1, "R6 write sets dirty");
    issue(16'h032A, mk(1,2,3,4,12'h000), 1'b1, "R7 write, no change");
    issue(16'h032A, mk(1,2,3,5,12'h123), 1'b0, "R5 read on read-only page");
    issue(16'h032A, mk(1,2,3,5,12'h123), 1'b1, "R5 write denied reason 3");
    issue(16'h032A, mk(1,2,3,6,12'h456), 1'b0, "R5 read denied reason 2");
    issue(16'h032A, mk(1,2,3,6,12'h456), 1'b1, "R5 write on write-only page");
    issue(16'h032A, mk(1,2,3,7,12'h001), 1'b0, "R4 leaf not present");
    issue(16'h032A, mk(1,2,3,8,12'h777), 1'b0, "R10 snoop and high bits ignored");
    issue(16'h032B, mk(1,2,3,4,12'h000), 1'b0, "R4 empty domain");
    issue(16'h072A, mk(1,2,3,4,12'h000), 1'b0, "R2 root entry absent");
    issue(16'h0330, mk(1,2,3,4,12'h000), 1'b1, "R2 context entry absent");
    issue(16'h032A, mk(1,2,5,0,12'h0AA), 1'b1, "R5 write denied at level 2");
    issue(16'h032A, mk(1,2,5,0,12'h0AA), 1'b0, "R3 read via level-2 path");
    issue(16'h032A, mk(0,2,3,4,12'h000), 1'b0, "R4 top-level entry absent");

    @(negedge clk);
    while (!req_ready || expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule